// File: doc/BRIEF.md
# Dual-Width Register Transfer Unit

This block holds the user-visible register set of an accumulator-oriented processor core whose accumulator and index registers each run at either 8 or 16 bits. It keeps a 16-bit accumulator (low byte A, hidden high byte B, both together called C), two index registers X and Y, a stack pointer S and a direct-page base D. Beside them it keeps the mode bits m (accumulator width), x (index width) and e (emulation), and the n, z and carry flags.

Each cycle in which `cmd_valid` is high, the unit executes one command named by `cmd_op`. A command is a register-to-register copy, a byte swap in the accumulator, a swap of carry with e, a register load from `cmd_data`, or a write of the flag bits. For copies, the width of the destination register decides how many bits are moved. The surrounding core fetches and decodes instructions and does memory and arithmetic work. It drives this unit and reads the register values straight from the outputs one cycle after the command.

Top module: `dwreg_xfer`

## Requirements
- R1: After reset: C=0x0000, X=0x0000, Y=0x0000, D=0x0000, S=0x01FF, e=1, m=1, x=1, and n=0, z=0, carry=0.
- R2: A copy writes at the destination's width. An 8-bit destination takes only the source's low byte. A 16-bit destination takes the full 16-bit source. So an 8-bit accumulator copied to a 16-bit index register gives B:A, and an 8-bit index register copied to a 16-bit accumulator gives a zero high byte.
- R3: While x=1, the high bytes of X and Y read 0x00. When x is set, both high bytes are cleared. When x returns to 0, the low bytes are unchanged.
- R4: While m=1, a copy or load into A changes only C[7:0]. B (C[15:8]) keeps its value.
- R5: C to D (op 6), D to C (op 7), C to S (op 8) and S to C (op 9) always move 16 bits, whatever m is. With m=1, D to C and S to C write the high byte into B.
- R6: Copies and the loads of A, X and Y set n from the destination's top bit and z when all destination-width bits are zero. X to S (op 3), load S (op 19) and load D (op 20) leave n and z unchanged.
- R7: A copy leaves its source register unchanged.
- R8: Op 12 swaps C[15:8] with C[7:0]. It then sets n from bit 7 of the new C and z from the new C[7:0] being zero, in either accumulator width.
- R9: Op 13 swaps carry with e. While e=1: m=1, x=1, and S[15:8]=0x01, including after any write to S.
- R10: Op codes: 0 A->X, 1 A->Y, 2 S->X, 3 X->S, 4 X->A, 5 Y->A, 6 C->D, 7 D->C, 8 C->S, 9 S->C, 10 X->Y, 11 Y->X, 12 byte swap, 13 carry/e swap, 16 load A, 17 load X, 18 load Y, 19 load S, 20 load D, 21 flag write. The loads take their value from cmd_data. Other codes, and any cycle with cmd_valid=0, change nothing.
- R11: The flag write (op 21) takes carry=data[0], z=data[1], x=data[2], m=data[3], n=data[4]. While e=1, m and x stay 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Execute cmd_op this cycle |
| cmd_op | input | 5 | Command code (see R10) |
| cmd_data | input | 16 | Load value or flag-write bits |
| reg_c | output | 16 | Accumulator B:A |
| reg_x | output | 16 | Index X |
| reg_y | output | 16 | Index Y |
| reg_s | output | 16 | Stack pointer |
| reg_d | output | 16 | Direct-page base |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_m | output | 1 | Accumulator is 8-bit |
| flag_x | output | 1 | Index registers are 8-bit |
| flag_e | output | 1 | Emulation mode |

## Verification
The embedded assertions check these on every cycle:
- the zero index high bytes in 8-bit index mode;
- the emulation invariants on m, x and the S high byte;
- B being kept on narrow accumulator writes;
- the untouched source on A->X;
- the unchanged flags on X->S;
- the byte swap and its n result;
- the idle cycle changing nothing.

Only the bench's scenarios can show that each mixed-width copy yields the exact expected value and that z follows the destination width. The same holds for the mode sequences: leaving and re-entering emulation, and clearing x and then setting it again.

// File: rtl/dwreg_xfer.sv
module dwreg_xfer #(
  parameter logic [15:0] RESET_S = 16'h01FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [4:0]  cmd_op,
  input  logic [15:0] cmd_data,
  output logic [15:0] reg_c,
  output logic [15:0] reg_x,
  output logic [15:0] reg_y,
  output logic [15:0] reg_s,
  output logic [15:0] reg_d,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_c,
  output logic        flag_m,
  output logic        flag_x,
  output logic        flag_e
);

  localparam logic [4:0] OP_AX = 5'd0,  OP_AY = 5'd1,  OP_SX = 5'd2,  OP_XS = 5'd3;
  localparam logic [4:0] OP_XA = 5'd4,  OP_YA = 5'd5,  OP_CD = 5'd6,  OP_DC = 5'd7;
  localparam logic [4:0] OP_CS = 5'd8,  OP_SC = 5'd9,  OP_XY = 5'd10, OP_YX = 5'd11;
  localparam logic [4:0] OP_SWB = 5'd12, OP_SWE = 5'd13;
  localparam logic [4:0] OP_LA = 5'd16, OP_LX = 5'd17, OP_LY = 5'd18, OP_LS = 5'd19;
  localparam logic [4:0] OP_LD = 5'd20, OP_FL = 5'd21;

  localparam logic [2:0] T_NONE = 3'd0, T_A = 3'd1, T_C = 3'd2, T_X = 3'd3;
  localparam logic [2:0] T_Y = 3'd4, T_S = 3'd5, T_D = 3'd6;

  logic [15:0] src;
  logic [2:0]  dst;
  logic        nz_en;
  logic        narrow;
  logic        res_n, res_z;
  logic        new_x, new_m;

  always_comb begin
    src   = 16'h0000;
    dst   = T_NONE;
    nz_en = 1'b1;
    case (cmd_op)
      OP_AX: begin src = reg_c; dst = T_X; end
      OP_AY: begin src = reg_c; dst = T_Y; end
      OP_SX: begin src = reg_s; dst = T_X; end
      OP_XS: begin src = reg_x; dst = T_S; nz_en = 1'b0; end
      OP_XA: begin src = reg_x; dst = T_A; end
      OP_YA: begin src = reg_y; dst = T_A; end
      OP_CD: begin src = reg_c; dst = T_D; end
      OP_DC: begin src = reg_d; dst = T_C; end
      OP_CS: begin src = reg_c; dst = T_S; end
      OP_SC: begin src = reg_s; dst = T_C; end
      OP_XY: begin src = reg_x; dst = T_Y; end
      OP_YX: begin src = reg_y; dst = T_X; end
      OP_LA: begin src = cmd_data; dst = T_A; end
      OP_LX: begin src = cmd_data; dst = T_X; end
      OP_LY: begin src = cmd_data; dst = T_Y; end
      OP_LS: begin src = cmd_data; dst = T_S; nz_en = 1'b0; end
      OP_LD: begin src = cmd_data; dst = T_D; nz_en = 1'b0; end
      default: nz_en = 1'b0;
    endcase
  end

  assign narrow = ((dst == T_A) && flag_m) || (((dst == T_X) || (dst == T_Y)) && flag_x);
  assign res_n  = narrow ? src[7] : src[15];
  assign res_z  = narrow ? (src[7:0] == 8'h00) : (src == 16'h0000);
  assign new_x  = cmd_data[2] | flag_e;
  assign new_m  = cmd_data[3] | flag_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_c  <= 16'h0000;
      reg_x  <= 16'h0000;
      reg_y  <= 16'h0000;
      reg_s  <= RESET_S;
      reg_d  <= 16'h0000;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_m <= 1'b1;
      flag_x <= 1'b1;
      flag_e <= 1'b1;
    end else if (cmd_valid) begin
      case (dst)
        T_A: reg_c <= flag_m ? {reg_c[15:8], src[7:0]} : src;
        T_C: reg_c <= src;
        T_X: reg_x <= flag_x ? {8'h00, src[7:0]} : src;
        T_Y: reg_y <= flag_x ? {8'h00, src[7:0]} : src;
        T_S: reg_s <= flag_e ? {8'h01, src[7:0]} : src;
        T_D: reg_d <= src;
        default: ;
      endcase
      if (nz_en) begin
        flag_n <= res_n;
        flag_z <= res_z;
      end
      case (cmd_op)
        OP_SWB: begin
          reg_c  <= {reg_c[7:0], reg_c[15:8]};
          flag_n <= reg_c[15];
          flag_z <= (reg_c[15:8] == 8'h00);
        end
        OP_SWE: begin
          flag_e <= flag_c;
          flag_c <= flag_e;
          if (flag_c) begin
            flag_m      <= 1'b1;
            flag_x      <= 1'b1;
            reg_x[15:8] <= 8'h00;
            reg_y[15:8] <= 8'h00;
            reg_s[15:8] <= 8'h01;
          end
        end
        OP_FL: begin
          flag_c <= cmd_data[0];
          flag_z <= cmd_data[1];
          flag_x <= new_x;
          flag_m <= new_m;
          flag_n <= cmd_data[4];
          if (new_x) begin
            reg_x[15:8] <= 8'h00;
            reg_y[15:8] <= 8'h00;
          end
        end
        default: ;
      endcase
    end
  end

  // R3: narrow index mode keeps both high bytes clear
  assert_idx_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_x |-> (reg_x[15:8] == 8'h00) && (reg_y[15:8] == 8'h00));

  // R9: emulation pins the widths and the stack page
  assert_emu_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_e |-> flag_m && flag_x && (reg_s[15:8] == 8'h01));

  // R4: narrow writes into A keep B
  assert_b_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && flag_m && (cmd_op == OP_XA || cmd_op == OP_YA || cmd_op == OP_LA)
    |=> reg_c[15:8] == $past(reg_c[15:8]));

  // R7: copy source is left alone
  assert_src_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_AX) |=> reg_c == $past(reg_c));

  // R6: X to S touches no flag
  assert_xs_no_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_XS) |=> flag_n == $past(flag_n) && flag_z == $past(flag_z));

  // R8: byte swap result and its sign flag
  assert_swap_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_SWB)
    |=> reg_c == {$past(reg_c[7:0]), $past(reg_c[15:8])} && flag_n == reg_c[7]);

  // R10: an idle cycle changes no state
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(reg_c) && $stable(reg_x) && $stable(reg_y) && $stable(reg_s)
                   && $stable(reg_d) && $stable({flag_n, flag_z, flag_c, flag_m, flag_x, flag_e}));

endmodule

// File: tb/tb_dwreg_xfer.sv
`timescale 1ns/1ps
module tb_dwreg_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_op = 5'd0;
  logic [15:0] cmd_data = 16'h0;
  logic [15:0] reg_c, reg_x, reg_y, reg_s, reg_d;
  logic        flag_n, flag_z, flag_c, flag_m, flag_x, flag_e;

  dwreg_xfer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .reg_c(reg_c), .reg_x(reg_x), .reg_y(reg_y), .reg_s(reg_s), .reg_d(reg_d),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_m(flag_m),
    .flag_x(flag_x), .flag_e(flag_e)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [15:0] mc, mx, my, ms, md;
  logic        mn, mz, mcy, mm, mxf, me;

  task automatic nz8(input logic [7:0] v);
    mn = v[7]; mz = (v == 8'h00);
  endtask
  task automatic nz16(input logic [15:0] v);
    mn = v[15]; mz = (v == 16'h0000);
  endtask
  task automatic put_a(input logic [15:0] v);
    if (mm) begin mc[7:0] = v[7:0]; nz8(v[7:0]); end
    else begin mc = v; nz16(v); end
  endtask
  task automatic put_idx(input logic [15:0] v, input bit to_y);
    logic [15:0] w;
    w = mxf ? {8'h00, v[7:0]} : v;
    if (mxf) nz8(v[7:0]); else nz16(v);
    if (to_y) my = w; else mx = w;
  endtask
  task automatic put_s(input logic [15:0] v, input bit fl);
    ms = me ? {8'h01, v[7:0]} : v;
    if (fl) nz16(v);
  endtask

  task automatic model(input logic [4:0] op, input logic [15:0] d);
    logic [15:0] t;
    case (op)
      5'd0:  put_idx(mc, 1'b0);
      5'd1:  put_idx(mc, 1'b1);
      5'd2:  put_idx(ms, 1'b0);
      5'd3:  put_s(mx, 1'b0);
      5'd4:  put_a(mx);
      5'd5:  put_a(my);
      5'd6:  begin md = mc; nz16(mc); end
      5'd7:  begin mc = md; nz16(md); end
      5'd8:  put_s(mc, 1'b1);
      5'd9:  begin mc = ms; nz16(ms); end
      5'd10: put_idx(mx, 1'b1);
      5'd11: put_idx(my, 1'b0);
      5'd12: begin t = {mc[7:0], mc[15:8]}; mc = t; nz8(t[7:0]); end
      5'd13: begin
        bit oc; oc = mcy; mcy = me; me = oc;
        if (me) begin mm = 1; mxf = 1; mx[15:8] = 0; my[15:8] = 0; ms[15:8] = 8'h01; end
      end
      5'd16: put_a(d);
      5'd17: put_idx(d, 1'b0);
      5'd18: put_idx(d, 1'b1);
      5'd19: put_s(d, 1'b0);
      5'd20: md = d;
      5'd21: begin
        mcy = d[0]; mz = d[1]; mn = d[4];
        mxf = d[2] | me; mm = d[3] | me;
        if (mxf) begin mx[15:8] = 0; my[15:8] = 0; end
      end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag);
    logic [85:0] act, exp;
    act = {reg_c, reg_x, reg_y, reg_s, reg_d, flag_n, flag_z, flag_c, flag_m, flag_x, flag_e};
    exp = {mc, mx, my, ms, md, mn, mz, mcy, mm, mxf, me};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [4:0] op, input logic [15:0] d, input string tag);
    cmd_valid = v; cmd_op = op; cmd_data = d;
    if (v) model(op, d);
    @(negedge clk);
    cmd_valid = 1'b0;
    compare(tag);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    mc = 0; mx = 0; my = 0; ms = 16'h01FF; md = 0;
    mn = 0; mz = 0; mcy = 0; mm = 1; mxf = 1; me = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset");
    step(1, 5'd13, 0, "R9 leave emulation");
    step(1, 5'd21, 16'h0000, "R11 wide modes");
    step(1, 5'd16, 16'h7F33, "R6 load wide A");
    step(1, 5'd1, 0, "R2 A16 to Y16");
    step(1, 5'd21, 16'h0008, "R11 m narrow");
    step(1, 5'd16, 16'h00FF, "R4 narrow load keeps B");
    step(1, 5'd5, 0, "R4 Y to A8 keeps B");
    step(1, 5'd0, 0, "R2 A8 to X16 takes B:A");
    step(1, 5'd21, 16'h000C, "R3 x set clears highs");
    step(1, 5'd21, 16'h0008, "R3 x clear keeps low");
    step(1, 5'd21, 16'h0004, "R11 m wide x narrow");
    step(1, 5'd4, 0, "R2 X8 to A16 zero high");
    step(1, 5'd16, 16'h8000, "R6 negative wide load");
    step(1, 5'd6, 0, "R5 C to D");
    step(1, 5'd21, 16'h000C, "R11 narrow both");
    step(1, 5'd16, 16'h0012, "R4 narrow load");
    step(1, 5'd8, 0, "R5 C to S full width");
    step(1, 5'd7, 0, "R5 D to C writes B");
    step(1, 5'd9, 0, "R5 S to C");
    step(1, 5'd21, 16'h001E, "R11 set n z");
    step(1, 5'd3, 0, "R6 X to S no flags");
    step(1, 5'd7, 0, "R5 reload 8000");
    step(1, 5'd12, 0, "R8 swap n from bit7");
    step(1, 5'd12, 0, "R8 swap z from low");
    step(1, 5'd10, 0, "R7 X to Y");
    step(1, 5'd25, 16'hFFFF, "R10 unused code");
    step(0, 5'd16, 16'h1234, "R10 idle");
    step(1, 5'd21, 16'h0001, "R11 carry set");
    step(1, 5'd13, 0, "R9 enter emulation");
    step(1, 5'd8, 0, "R9 S page forced");
    step(1, 5'd21, 16'h0000, "R11 m x held in emulation");
    step(1, 5'd19, 16'hABCD, "R9 load S forced");
    step(1, 5'd13, 0, "R9 leave again");

    void'($urandom(32'd20250417));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      op = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 21));
      step($urandom_range(0, 7) != 0, op, 16'($urandom), "R2 R6 R7 R10 random");
    end
    summary();
    $finish;
  end
endmodule